// File: doc/BRIEF.md
# I2C SCL Timing Tick Divider

This block turns the system clock into the timing reference for an I2C bit engine. A 7-bit rate setting holds two fields, a mantissa M and an exponent N. The clock first passes through a power-of-two prescaler set by N. The prescaler's enable then passes through a divide-by-(M+1) stage. The result is a one-cycle tick at ten times the SCL rate. Each tick advances a ten-step phase sequencer. The bit engine uses the sequencer to place SCL edges, the SDA update point and the SDA sample point.

Writing a new rate setting restarts every counter from zero, so the first SCL period at the new rate is complete. A cleared enable input holds the whole chain at zero. A soft reset does the same and also restores the power-on rate setting. A parameter selects the alternative scaling, in which the prescaler divides by 2^N instead of 2^(N+1).

Top module: `scl_tick_gen`

## Requirements
- R1: After reset the rate setting is 0x44 (M=8, N=4). With `run_en` high and `soft_clr` low, the tick period is 288 clocks, and the first tick comes in the 288th cycle counted from the cycle in which `rst_n` is released.
- R2: The rate setting holds M in bits 6:3 and N in bits 2:0. The tick period is (M+1)·2^(N+1) clocks, from 2 (setting 0x00) up to 4096 (setting 0x7F).
- R3: `tick` is high for exactly one clock per period and is never high in two consecutive cycles.
- R4: `phase` starts at 0 and advances by one on each tick, wrapping from 9 back to 0. Between ticks it holds its value.
- R5: `scl_high` is 1 exactly while `phase` is 5 to 9, and `phase` never exceeds 9.
- R6: `sda_upd` is high together with the tick that moves `phase` from 1 to 2. `sda_smp` is high together with the tick that moves `phase` from 6 to 7. Neither is ever high without `tick`.
- R7: A cycle with `rate_wr` high loads `rate_wdata` and has no tick. In the next cycle all counters and `phase` are 0, and the first tick at the new rate comes D cycles after the write cycle, where D is the new period.
- R8: While `run_en` is low there are no ticks and `phase` is 0. The rate setting is kept. When `run_en` rises, the first tick comes D−1 cycles after the first enabled cycle.
- R9: While `soft_clr` is high the block behaves as in R8, and the rate setting returns to 0x44. After release, the first tick comes 287 cycles after the first released cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of counters, restores default rate |
| run_en | input | 1 | Controller enable; low holds the dividers at zero |
| rate_wr | input | 1 | Write strobe for the rate setting |
| rate_wdata | input | 7 | New rate setting, M in 6:3, N in 2:0 |
| tick | output | 1 | One-cycle pulse at ten times the SCL rate |
| phase | output | 4 | Current phase within the SCL period, 0 to 9 |
| scl_high | output | 1 | SCL level for the current phase |
| sda_upd | output | 1 | Tick qualifier: SDA may change now |
| sda_smp | output | 1 | Tick qualifier: SDA is sampled now |

## Verification
A prescaler or mantissa counter in a wrong state does not show at once. It shows up at the next tick, which comes early or late. That can take up to 4096 clocks at the slowest setting, so every tick is compared against its exact expected cycle number. A corrupted phase counter becomes visible within one tick period, through `phase`, `scl_high` or a strobe appearing at the wrong step. A restart that fails after a write, a disable or a soft clear shifts every later tick. Each such event is therefore followed by a stream of cycle-exact expectations.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
    localparam int DEF_EXP_W   = 3;
    localparam int DEF_MANT_W  = 4;
    localparam int DEF_PHASE_N = 10;
    localparam int DEF_SDA_CHG = 2;
    localparam int DEF_SDA_SMP = 7;
    localparam int DEF_SCL_HI  = 5;
    localparam int DEF_RATE    = 'h44;

    function automatic int tick_period(input int mant, input int expo, input int extra);
        return (mant + 1) * (1 << (expo + extra));
    endfunction
endpackage

// File: rtl/sdiv_prescale.sv
module sdiv_prescale #(
    parameter int EXP_W = 3,
    parameter int EXTRA = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [EXP_W-1:0] expo,
    output logic             pulse
);
    localparam int CNT_W = (1 << EXP_W) - 1 + EXTRA;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [CNT_W-1:0] lim;
    logic [EXP_W:0]   shamt;

    generate
        if (EXTRA != 0) begin : g_shift_plus
            assign shamt = {1'b0, expo} + 1'b1;
        end else begin : g_shift_plain
            assign shamt = {1'b0, expo};
        end
    endgenerate

    always_comb begin
        lim  = ~({CNT_W{1'b1}} << shamt);
        st_d = st_q;
        pulse = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == lim) begin
            st_d.cnt = '0;
            pulse    = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sdiv_mant.sv
module sdiv_mant #(
    parameter int MANT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic [MANT_W-1:0] mant,
    output logic              pulse
);
    typedef struct packed {
        logic [MANT_W-1:0] cnt;
    } man_st_t;

    man_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        pulse = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (step) begin
            if (st_q.cnt == mant) begin
                st_d.cnt = '0;
                pulse    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sdiv_phase.sv
module sdiv_phase #(
    parameter int PHASE_N = 10,
    parameter int SDA_CHG = 2,
    parameter int SDA_SMP = 7,
    parameter int SCL_HI  = 5,
    localparam int PH_W   = $clog2(PHASE_N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            step,
    output logic [PH_W-1:0] phase,
    output logic            scl_high,
    output logic            upd,
    output logic            smp
);
    typedef struct packed {
        logic [PH_W-1:0] ph;
    } ph_st_t;

    ph_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.ph = '0;
        end else if (step) begin
            st_d.ph = (st_q.ph == PH_W'(PHASE_N - 1)) ? '0 : st_q.ph + 1'b1;
        end
        upd      = step && (st_q.ph == PH_W'(SDA_CHG - 1));
        smp      = step && (st_q.ph == PH_W'(SDA_SMP - 1));
        scl_high = (st_q.ph >= PH_W'(SCL_HI));
        phase    = st_q.ph;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen
    import scl_div_pkg::*;
#(
    parameter int EXP_W    = DEF_EXP_W,
    parameter int MANT_W   = DEF_MANT_W,
    parameter int EXTRA    = 1,
    parameter int PHASE_N  = DEF_PHASE_N,
    parameter int SDA_CHG  = DEF_SDA_CHG,
    parameter int SDA_SMP  = DEF_SDA_SMP,
    parameter int SCL_HI   = DEF_SCL_HI,
    parameter int RATE_RST = DEF_RATE,
    localparam int RATE_W  = MANT_W + EXP_W,
    localparam int PH_W    = $clog2(PHASE_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              run_en,
    input  logic              rate_wr,
    input  logic [RATE_W-1:0] rate_wdata,
    output logic              tick,
    output logic [PH_W-1:0]   phase,
    output logic              scl_high,
    output logic              sda_upd,
    output logic              sda_smp
);
    typedef struct packed {
        logic [RATE_W-1:0] rate;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    clr_all;
    logic    pre_pulse;

    always_comb begin
        st_d    = st_q;
        clr_all = soft_clr || !run_en || rate_wr;
        if (soft_clr)     st_d.rate = RATE_W'(RATE_RST);
        else if (rate_wr) st_d.rate = rate_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.rate <= RATE_W'(RATE_RST);
        else        st_q <= st_d;
    end

    sdiv_prescale #(.EXP_W(EXP_W), .EXTRA(EXTRA)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_all),
        .expo  (st_q.rate[EXP_W-1:0]),
        .pulse (pre_pulse)
    );

    sdiv_mant #(.MANT_W(MANT_W)) u_man (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_all),
        .step  (pre_pulse),
        .mant  (st_q.rate[RATE_W-1:EXP_W]),
        .pulse (tick)
    );

    sdiv_phase #(
        .PHASE_N (PHASE_N),
        .SDA_CHG (SDA_CHG),
        .SDA_SMP (SDA_SMP),
        .SCL_HI  (SCL_HI)
    ) u_ph (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_all),
        .step     (tick),
        .phase    (phase),
        .scl_high (scl_high),
        .upd      (sda_upd),
        .smp      (sda_smp)
    );
endmodule

// File: rtl/scl_tick_chk.sv
module scl_tick_chk #(
    parameter int PH_W    = 4,
    parameter int PHASE_N = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            soft_clr,
    input logic            run_en,
    input logic            rate_wr,
    input logic            tick,
    input logic [PH_W-1:0] phase,
    input logic            scl_high,
    input logic            sda_upd,
    input logic            sda_smp
);
    // R3
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && run_en && !soft_clr && !rate_wr) |=> $stable(phase));

    // R4
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && phase != PH_W'(PHASE_N - 1)) |=> phase == $past(phase) + 1'b1);

    // R4
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && phase == PH_W'(PHASE_N - 1)) |=> phase == '0);

    // R5
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase < PH_W'(PHASE_N));

    // R5
    scl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_high) |-> ($past(tick) && phase == PH_W'(5)));

    // R6
    upd_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_upd |=> (phase == PH_W'(2) && !scl_high));

    // R6
    smp_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_smp |=> (phase == PH_W'(7) && scl_high));

    // R7
    wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_wr |-> !tick);

    // R7
    wr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_wr |=> phase == '0);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en || soft_clr) |-> (!tick && !sda_upd && !sda_smp));

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en || soft_clr) |=> phase == '0);
endmodule

bind scl_tick_gen scl_tick_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_clr),
    .run_en   (run_en),
    .rate_wr  (rate_wr),
    .tick     (tick),
    .phase    (phase),
    .scl_high (scl_high),
    .sda_upd  (sda_upd),
    .sda_smp  (sda_smp)
);

// File: tb/sim_scl_tick_gen.sv
`timescale 1ns/1ps
module sim_scl_tick_gen;
    logic       clk = 1'b0;
    logic       rst_n, soft_clr, run_en, rate_wr;
    logic [6:0] rate_wdata;
    logic       tick, scl_high, sda_upd, sda_smp;
    logic [3:0] phase;

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    typedef struct {
        int    cyc;
        int    ph;
        string req;
    } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    scl_tick_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_clr   (soft_clr),
        .run_en     (run_en),
        .rate_wr    (rate_wr),
        .rate_wdata (rate_wdata),
        .tick       (tick),
        .phase      (phase),
        .scl_high   (scl_high),
        .sda_upd    (sda_upd),
        .sda_smp    (sda_smp)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int period_of(input int rate);
        return ((rate >> 3) + 1) * (1 << ((rate & 7) + 1));
    endfunction

    task automatic push_run(input int first, input int d, input int n, input string req);
        for (int k = 0; k < n; k++) begin
            item_t it;
            it.cyc = first + k * d;
            it.ph  = k % 10;
            it.req = req;
            exp_q.push_back(it);
        end
    endtask

    task automatic step_to(input int target);
        while (cyc < target) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic next_cycle();
        @(posedge clk);
        #1;
    endtask

    task automatic close_run(input string req);
        chk(exp_q.size() == 0, req, "missing ticks", exp_q.size(), 0);
        exp_q.delete();
    endtask

    // Monitor: compares every observed tick against the scoreboard.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && tick === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, cur_req, "unexpected tick at cycle", cyc, -1);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                chk(cyc == it.cyc, it.req, "tick cycle", cyc, it.cyc);
                chk(int'(phase) == it.ph, "R4", "phase at tick", int'(phase), it.ph);
                chk(scl_high == (it.ph >= 5), "R5", "scl_high at tick",
                    int'(scl_high), int'(it.ph >= 5));
                chk(sda_upd == (it.ph == 1), "R6", "sda_upd", int'(sda_upd), int'(it.ph == 1));
                chk(sda_smp == (it.ph == 6), "R6", "sda_smp", int'(sda_smp), int'(it.ph == 6));
            end
        end
    end

    task automatic write_rate(input int rate, input int n, input string req);
        int c, d;
        cur_req    = req;
        rate_wr    = 1'b1;
        rate_wdata = 7'(rate);
        c = cyc;
        d = period_of(rate);
        chk(tick == 1'b0, "R7", "tick in write cycle", int'(tick), 0);
        push_run(c + d, d, n, req);
        next_cycle();
        rate_wr = 1'b0;
        chk(phase == 4'd0, "R7", "phase after write", int'(phase), 0);
        step_to(c + n * d + 1);
        close_run(req);
    endtask

    initial begin
        rst_n = 1'b0; soft_clr = 1'b0; run_en = 1'b1; rate_wr = 1'b0; rate_wdata = '0;
        repeat (3) next_cycle();
        chk(tick == 1'b0, "R1", "tick in reset", int'(tick), 0);
        chk(phase == 4'd0, "R1", "phase in reset", int'(phase), 0);
        chk(scl_high == 1'b0, "R5", "scl in reset", int'(scl_high), 0);

        // R1: default rate 0x44 gives 288 clocks per tick
        begin
            int c;
            cur_req = "R1";
            rst_n = 1'b1;
            c = cyc;
            push_run(c + 287, 288, 3, "R1");
            step_to(c + 287 + 2 * 288 + 1);
            close_run("R1");
        end

        // R2: fastest setting, runs past two phase wraps (R4)
        write_rate('h00, 25, "R2");
        // R7: write lands mid-sequence (phase 5), restart from phase 0
        write_rate('h1A, 12, "R7");

        // R8: disable holds everything, rate kept
        begin
            int c;
            cur_req = "R8";
            run_en = 1'b0;
            repeat (300) next_cycle();
            chk(phase == 4'd0, "R8", "phase while disabled", int'(phase), 0);
            chk(scl_high == 1'b0, "R8", "scl while disabled", int'(scl_high), 0);
            run_en = 1'b1;
            c = cyc;
            push_run(c + 31, 32, 3, "R8");
            step_to(c + 31 + 2 * 32 + 1);
            close_run("R8");
        end

        // R2: slowest setting
        write_rate('h7F, 2, "R2");
        // R2: odd mantissa, small exponent
        write_rate('h2B, 11, "R2");

        // R9: soft clear restores default rate
        begin
            int c;
            cur_req = "R9";
            soft_clr = 1'b1;
            repeat (4) next_cycle();
            chk(phase == 4'd0, "R9", "phase during soft clear", int'(phase), 0);
            chk(tick == 1'b0, "R9", "tick during soft clear", int'(tick), 0);
            soft_clr = 1'b0;
            c = cyc;
            push_run(c + 287, 288, 2, "R9");
            step_to(c + 287 + 288 + 1);
            close_run("R9");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog %s actual=%0d expected=%0d", cur_req, cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule